// File: doc/BRIEF.md
# Interleaved Four-Port Bank Controller

This block is a memory-port controller that lets four requesters share four independent memory banks. Port 0 belongs to the CPU and ports 1 to 3 to I/O channels. Each port presents a request, a flat word address, a write enable and write data. The block works out which bank each address falls in and grants each bank to at most one port per cycle, so ports that target different banks are served in the same cycle.

A mode input picks how a flat address is split into a bank number and a word number. In block mode, consecutive addresses stay inside one bank. This lets separate requesters work in separate regions without conflict. In striped mode, consecutive addresses rotate across the banks. A single port can then walk a run of addresses one per cycle while each access lands in a fresh bank. The banks are register arrays held inside the block, and they are cleared on reset.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, every `ack` bit and every `rdata` byte is 0. After reset, every stored word reads as 0.
- R2: When `lo_mode` is 0 (block mode), address bits [5:4] select the bank and bits [3:0] select the word inside it.
- R3: When `lo_mode` is 1 (striped mode), address bits [1:0] select the bank and bits [5:2] select the word. Both modes address the same storage: physical word (bank b, word w) is reached by block address {b,w} and by striped address {w,b}.
- R4: A requesting port whose bank no other port requests in that cycle is always granted in that cycle. When all four ports target different banks, all four are granted together.
- R5: When several ports request the same bank, the lowest-numbered port wins (port 0 the CPU, then ports 1, 2 and 3). A losing port keeps its request asserted and is served in a later cycle.
- R6: `ack` for port p is high in exactly the cycle after port p was granted, and is low after any cycle in which port p did not request.
- R7: In striped mode, one port that presents addresses n, n+1, n+2, n+3 on successive cycles receives an acknowledge on each of four successive cycles.
- R8: `lo_mode` may change only in a cycle where no `req` bit is high. The mapping applies from the next request on.
- R9: A granted read returns the addressed word on `rdata`. A granted write stores `wdata`, and `rdata` on that acknowledge carries the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_mode | input | 1 | 0 = block mapping, 1 = striped mapping |
| req | input | 4 | Per-port request, bit p for port p |
| wen | input | 4 | Per-port write enable |
| addr | input | 24 | Per-port 6-bit address, port p in bits [6p+5:6p] |
| wdata | input | 32 | Per-port write byte, port p in bits [8p+7:8p] |
| ack | output | 4 | Per-port acknowledge, one cycle after the grant |
| rdata | output | 32 | Per-port read byte, port p in bits [8p+7:8p] |

## Verification
Four patterns exercise the block-mode grant logic. In the first, all four ports hit distinct banks at once, which shows that the banks run in parallel. In the second, all four ports pile onto one bank, which shows the priority order and how held requests drain one per cycle. In the third, two ports collide while the other two do not, which shows that a collision does not stall an unrelated bank. In striped mode, one port walks consecutive addresses to show one access per cycle. Then all four ports write a consecutive run and the same words are read back in block mode. Data that was written through one mapping and read through the other shows whether both mappings decode to the same physical words.

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
  parameter int NPORT = 4,
  parameter int NBANK = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int BW = $clog2(NBANK),
  localparam int WW = $clog2(DEPTH),
  localparam int AW = BW + WW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_mode,
  input  logic [NPORT-1:0]    req,
  input  logic [NPORT-1:0]    wen,
  input  logic [NPORT*AW-1:0] addr,
  input  logic [NPORT*DW-1:0] wdata,
  output logic [NPORT-1:0]    ack,
  output logic [NPORT*DW-1:0] rdata
);

  logic [NPORT-1:0][BW-1:0] bsel;
  logic [NPORT-1:0][WW-1:0] wsel;
  logic [NPORT-1:0]         grant;
  logic [DW-1:0]            mem [NBANK*DEPTH];

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      if (lo_mode) begin
        bsel[p] = addr[p*AW +: BW];
        wsel[p] = addr[p*AW+BW +: WW];
      end else begin
        bsel[p] = addr[p*AW+WW +: BW];
        wsel[p] = addr[p*AW +: WW];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      grant[p] = req[p];
      for (int q = 0; q < p; q++)
        if (req[q] && bsel[q] == bsel[p]) grant[p] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= '0;
      rdata <= '0;
      for (int i = 0; i < NBANK*DEPTH; i++) mem[i] <= '0;
    end else begin
      ack <= grant;
      for (int p = 0; p < NPORT; p++) begin
        if (grant[p]) begin
          rdata[p*DW +: DW] <= mem[{bsel[p], wsel[p]}];
          if (wen[p]) mem[{bsel[p], wsel[p]}] <= wdata[p*DW +: DW];
        end
      end
    end
  end

endmodule

// File: rtl/ilv_bank_ctrl_chk.sv
module ilv_bank_ctrl_chk #(
  parameter int NPORT = 4,
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lo_mode,
  input logic [NPORT-1:0]         req,
  input logic [NPORT-1:0]         ack,
  input logic [NPORT-1:0]         grant,
  input logic [NPORT-1:0][BW-1:0] bsel
);

  logic [NBANK-1:0][NPORT-1:0] bank_hits;
  logic [NPORT-1:0]            alone;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      for (int p = 0; p < NPORT; p++)
        bank_hits[b][p] = grant[p] && (int'(bsel[p]) == b);
    for (int p = 0; p < NPORT; p++) begin
      alone[p] = req[p];
      for (int q = 0; q < NPORT; q++)
        if (q != p && req[q] && bsel[q] == bsel[p]) alone[p] = 1'b0;
    end
  end

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_hits[b]) <= 1);
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      p_ack_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant[p] |=> ack[p]);
      p_no_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req[p] |=> !ack[p]);
      p_lone_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alone[p] |=> ack[p]);
    end
  endgenerate

  p_cpu_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |=> ack[0]);

  p_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $stable(lo_mode));

endmodule

bind ilv_bank_ctrl ilv_bank_ctrl_chk #(.NPORT(NPORT), .NBANK(NBANK), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_mode(lo_mode), .req(req),
  .ack(ack), .grant(grant), .bsel(bsel)
);

// File: tb/ilv_bank_ctrl_tb.sv
module ilv_bank_ctrl_tb;
  localparam int NP = 4;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NV = 16;

  typedef struct packed {
    logic       lo;
    logic [3:0] rq, we;
    logic [5:0] a3, a2, a1, a0;
    logic [7:0] d3, d2, d1, d0;
    logic [3:0] ex;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'hF, 4'hF, 6'h3F, 6'h2A, 6'h15, 6'h00, 8'h44, 8'h33, 8'h22, 8'h11, 4'hF}, // R2 R4
    '{1'b0, 4'hF, 4'h0, 6'h3F, 6'h2A, 6'h15, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'hF}, // R4 R9
    '{1'b0, 4'hF, 4'hF, 6'h13, 6'h12, 6'h11, 6'h10, 8'hA3, 8'hA2, 8'hA1, 8'hA0, 4'h1}, // R5
    '{1'b0, 4'hE, 4'hF, 6'h13, 6'h12, 6'h11, 6'h10, 8'hA3, 8'hA2, 8'hA1, 8'hA0, 4'h2}, // R5
    '{1'b0, 4'hC, 4'hF, 6'h13, 6'h12, 6'h11, 6'h10, 8'hA3, 8'hA2, 8'hA1, 8'hA0, 4'h4}, // R5
    '{1'b0, 4'h8, 4'hF, 6'h13, 6'h12, 6'h11, 6'h10, 8'hA3, 8'hA2, 8'hA1, 8'hA0, 4'h8}, // R5
    '{1'b0, 4'hF, 4'h0, 6'h21, 6'h30, 6'h20, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h7}, // R5 R4
    '{1'b0, 4'h8, 4'h0, 6'h21, 6'h30, 6'h20, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h8}, // R5
    '{1'b1, 4'h0, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0}, // R8 R6
    '{1'b1, 4'h4, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h4}, // R7 R3
    '{1'b1, 4'h4, 4'h0, 6'h00, 6'h01, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h4}, // R7 R3
    '{1'b1, 4'h4, 4'h0, 6'h00, 6'h02, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h4}, // R7 R3
    '{1'b1, 4'h4, 4'h0, 6'h00, 6'h03, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h4}, // R7 R3
    '{1'b1, 4'hF, 4'hF, 6'h07, 6'h06, 6'h05, 6'h04, 8'h88, 8'h77, 8'h66, 8'h55, 4'hF}, // R3 R4 R9
    '{1'b0, 4'h0, 4'h0, 6'h00, 6'h00, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0}, // R8
    '{1'b0, 4'hF, 4'h0, 6'h31, 6'h21, 6'h11, 6'h01, 8'h00, 8'h00, 8'h00, 8'h00, 4'hF}  // R3 R2
  };

  logic clk = 1'b0;
  logic rst_n;
  logic lo_mode;
  logic [NP-1:0] req, wen, ack;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wdata, rdata;
  logic [7:0] model [64];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ilv_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lo_mode(lo_mode), .req(req), .wen(wen),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata)
  );

  function automatic logic [5:0] phys(input logic lo, input logic [5:0] a);
    return lo ? {a[1:0], a[5:2]} : a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req = '0; wen = '0; addr = '0; wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lo_mode = 1'b0; idle();
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", ack, 0);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", ack, 0);
    chk("R1 rdata after reset", rdata, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [5:0] pa;
      v = VEC[i];
      lo_mode = v.lo; req = v.rq; wen = v.we;
      addr = {v.a3, v.a2, v.a1, v.a0};
      wdata = {v.d3, v.d2, v.d1, v.d0};
      @(negedge clk);
      chk($sformatf("vector %0d ack (R4 R5 R6 R7)", i), ack, v.ex);
      for (int p = 0; p < NP; p++) begin
        if (v.ex[p]) begin
          pa = phys(v.lo, addr[p*AW +: AW]);
          chk($sformatf("vector %0d port %0d rdata (R2 R3 R9)", i, p),
              rdata[p*DW +: DW], model[pa]);
        end
      end
      for (int p = 0; p < NP; p++)
        if (v.ex[p] && v.we[p]) model[phys(v.lo, addr[p*AW +: AW])] = wdata[p*DW +: DW];
    end

    idle();
    @(negedge clk);
    chk("R6 no ack without request", ack, 0);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ack during mid-run reset", ack, 0);
    chk("R1 rdata during mid-run reset", rdata, 0);
    rst_n = 1'b1;
    lo_mode = 1'b0; req = 4'h1; addr = {18'h0, 6'h01};
    @(negedge clk);
    chk("R1 ack of read after reset", ack, 4'h1);
    chk("R1 memory cleared by reset", rdata[7:0], 8'h00);
    idle();
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule